// File: doc/BRIEF.md
# Linear Sensor Readout Sequencer

This block sits on the host side of a two-section, 1280-element linear photodiode array whose sections are chained, so that the shift output of the first section feeds the start input of the second. From the system clock it generates the sensor clock, the combined start/hold pulse, and one ADC sample strobe for every pixel with the pixel's index. Each strobe is held back by a programmable number of system clocks after the sensor clock edge that puts the pixel on the analog output, so that the output has time to settle before it is sampled.

A small write-only register port sets the half period of the sensor clock, the settle delay and the integration count, and issues single-frame starts or turns continuous mode on and off. The start pulse is one sensor clock period long. A frame has exactly one more sensor clock than there are pixels, because the extra clock ends the last shift output pulse. Integration is counted from the end of the sensor's integrator reset window, which lasts a fixed number of sensor clocks after the start. The next start pulse waits until that count has run out. Settings that would break the sensor's timing limits cause the start to be refused.

Top module: `lsa_readout_seq`

## Requirements
- R1: After reset, sensor_clk, sensor_si, adc_strobe and frame_done are all low, and nothing moves until a start is accepted.
- R2: An accepted frame has exactly PIXELS+1 rising edges of sensor_clk. Every high phase and every low phase lasts the programmed half period (register address 4) in system clocks, and sensor_clk stays low between frames.
- R3: sensor_si rises while sensor_clk is low, one half period before the first rising edge. It falls together with the first falling edge, so it is high for exactly two half periods.
- R4: For rising edges k = 1..PIXELS, adc_strobe is high for one system clock exactly SETTLE system clocks after sensor_clk goes high (settle register, address 6), with pixel_idx = k-1. No strobe follows edge PIXELS+1.
- R5: frame_done is high for one system clock, in the cycle in which sensor_clk falls after edge PIXELS+1.
- R6: The integration count (address 5) is loaded when rising edge RESET_CLKS+1 occurs. The next sensor_si rise comes no earlier than count+1 system clocks after that edge. If the count has already expired, it comes one system clock after frame_done.
- R7: A start is refused, with no sensor_si and no sensor_clk activity, in any of these cases: half period < MIN_HALF, settle < MIN_SETTLE, settle >= 2 × half period, or integration count < MIN_INT.
- R8: The half period, settle and integration values are captured when a frame launches. Writes made during a frame do not change that frame.
- R9: A write to address 0 (data ignored) requests one frame. A request made during a frame launches one further frame after it, and after that no frame follows.
- R10: A write to address 1 turns continuous mode on, so frames repeat back to back. A write to address 2 turns it off, and frames stop after the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register address (0 start, 1 continuous on, 2 continuous off, 4 half period, 5 integration, 6 settle) |
| wr_data | input | CFG_W | Register write data |
| sensor_clk | output | 1 | Clock to the sensor array |
| sensor_si | output | 1 | Combined start and hold pulse |
| adc_strobe | output | 1 | ADC sample strobe, one per pixel |
| pixel_idx | output | $clog2(PIXELS) | Index of the pixel being strobed |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest case to reach from the ports is an integration count that is longer than the rest of the frame, because only then does the integration counter, and not the end of the frame, decide when the next start pulse comes. The stimulus runs continuous mode with a count larger than the roughly 5000 system clocks left after the reset window. It measures the gap from the edge that ends the reset window to the next start rise. It then shortens the count while a frame is running, which shows both that the new value is captured at launch and that back-to-back frames follow done by a single cycle.

// File: rtl/lsa_seq_pkg.sv
package lsa_seq_pkg;

    localparam int CFG_W  = 24;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_START    = 3'd0,
        ADDR_CONT_ON  = 3'd1,
        ADDR_CONT_OFF = 3'd2,
        ADDR_HALF     = 3'd4,
        ADDR_INTEG    = 3'd5,
        ADDR_SETTLE   = 3'd6
    } reg_addr_e;

    typedef enum logic {
        FR_IDLE,
        FR_RUN
    } frame_st_e;

    typedef struct packed {
        logic [CFG_W-1:0] half;
        logic [CFG_W-1:0] integ;
        logic [CFG_W-1:0] settle;
    } seq_cfg_t;

    // A setting is usable when it keeps phase width, settle window and
    // integration time inside the sensor's limits.
    function automatic logic cfg_valid(seq_cfg_t c, int unsigned min_half,
                                       int unsigned min_settle, int unsigned min_int);
        int unsigned h;
        int unsigned s;
        int unsigned n;
        h = 32'(c.half);
        s = 32'(c.settle);
        n = 32'(c.integ);
        return (h >= min_half) && (s >= min_settle) && (s < 2 * h) && (n >= min_int);
    endfunction

endpackage

// File: rtl/seq_cfg_regs.sv
module seq_cfg_regs
    import lsa_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CFG_W-1:0]  wr_data,
    output seq_cfg_t          cfg,
    output logic              cont_mode,
    output logic              start_req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            cont_mode <= 1'b0;
            start_req <= 1'b0;
        end else begin
            start_req <= 1'b0;
            if (wr_en) begin
                case (reg_addr_e'(wr_addr))
                    ADDR_START:    start_req  <= 1'b1;
                    ADDR_CONT_ON:  cont_mode  <= 1'b1;
                    ADDR_CONT_OFF: cont_mode  <= 1'b0;
                    ADDR_HALF:     cfg.half   <= wr_data;
                    ADDR_INTEG:    cfg.integ  <= wr_data;
                    ADDR_SETTLE:   cfg.settle <= wr_data;
                    default:       ;
                endcase
            end
        end
    end

endmodule

// File: rtl/seq_sclk_gen.sv
module seq_sclk_gen
    import lsa_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CFG_W-1:0] half,
    output logic             sclk,
    output logic             tick_rise,
    output logic             tick_fall
);

    logic [CFG_W-1:0] ph_cnt;
    logic             ph_end;

    assign ph_end    = run && (ph_cnt == half - CFG_W'(1));
    assign tick_rise = ph_end && !sclk;
    assign tick_fall = ph_end && sclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ph_cnt <= '0;
            sclk   <= 1'b0;
        end else if (ph_end) begin
            ph_cnt <= '0;
            sclk   <= ~sclk;
        end else begin
            ph_cnt <= ph_cnt + CFG_W'(1);
        end
    end

endmodule

// File: rtl/seq_frame_ctl.sv
module seq_frame_ctl
    import lsa_seq_pkg::*;
#(
    parameter int PIXELS     = 1280,
    parameter int RESET_CLKS = 18,
    localparam int EDGE_W    = $clog2(PIXELS + 2)
)(
    input  logic              clk,
    input  logic              rst,
    input  seq_cfg_t          cfg,
    input  logic              cfg_ok,
    input  logic              start_req,
    input  logic              cont_mode,
    input  logic              tick_rise,
    input  logic              tick_fall,
    output logic              run,
    output logic              si,
    output logic              done,
    output logic [CFG_W-1:0]  act_half,
    output logic [CFG_W-1:0]  act_settle,
    output logic [EDGE_W-1:0] edge_cnt,
    output logic              int_zero
);

    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(PIXELS + 1);
    localparam logic [EDGE_W-1:0] INT_EDGE  = EDGE_W'(RESET_CLKS + 1);

    frame_st_e        st;
    logic             armed;
    logic [CFG_W-1:0] act_integ;
    logic [CFG_W-1:0] int_cnt;
    logic             want;
    logic             launch;
    logic             refuse;

    assign int_zero = (int_cnt == '0);
    assign want     = (st == FR_IDLE) && int_zero && (armed || cont_mode);
    assign launch   = want && cfg_ok;
    assign refuse   = want && !cfg_ok;
    assign run      = (st == FR_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= FR_IDLE;
            armed      <= 1'b0;
            si         <= 1'b0;
            done       <= 1'b0;
            edge_cnt   <= '0;
            act_half   <= '0;
            act_settle <= '0;
            act_integ  <= '0;
            int_cnt    <= '0;
        end else begin
            done <= 1'b0;
            if (launch || refuse) armed <= 1'b0;
            if (start_req)        armed <= 1'b1;

            if (int_cnt != '0) int_cnt <= int_cnt - CFG_W'(1);

            if (launch) begin
                st         <= FR_RUN;
                si         <= 1'b1;
                edge_cnt   <= '0;
                act_half   <= cfg.half;
                act_settle <= cfg.settle;
                act_integ  <= cfg.integ;
            end else if (st == FR_RUN) begin
                if (tick_rise) begin
                    edge_cnt <= edge_cnt + EDGE_W'(1);
                    if (edge_cnt + EDGE_W'(1) == INT_EDGE) int_cnt <= act_integ;
                end
                if (tick_fall) begin
                    if (edge_cnt == EDGE_W'(1)) si <= 1'b0;
                    if (edge_cnt == LAST_EDGE) begin
                        st   <= FR_IDLE;
                        done <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/seq_strobe_gen.sv
module seq_strobe_gen
    import lsa_seq_pkg::*;
#(
    parameter int PIXELS   = 1280,
    localparam int EDGE_W  = $clog2(PIXELS + 2),
    localparam int IDX_W   = $clog2(PIXELS)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_rise,
    input  logic [EDGE_W-1:0] edge_cnt,
    input  logic [CFG_W-1:0]  settle,
    output logic              strobe,
    output logic [IDX_W-1:0]  pix_idx
);

    logic             pend;
    logic [CFG_W-1:0] dly;

    assign strobe = pend && (dly == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            dly     <= '0;
            pix_idx <= '0;
        end else if (tick_rise && (edge_cnt < EDGE_W'(PIXELS))) begin
            pend    <= 1'b1;
            dly     <= settle;
            pix_idx <= edge_cnt[IDX_W-1:0];
        end else if (pend) begin
            if (dly == '0) pend <= 1'b0;
            else           dly  <= dly - CFG_W'(1);
        end
    end

endmodule

// File: rtl/lsa_readout_seq.sv
module lsa_readout_seq
    import lsa_seq_pkg::*;
#(
    parameter int PIXELS     = 1280,
    parameter int RESET_CLKS = 18,
    parameter int MIN_HALF   = 13,
    parameter int MIN_SETTLE = 30,
    parameter int MIN_INT    = 40500,
    localparam int IDX_W     = $clog2(PIXELS),
    localparam int EDGE_W    = $clog2(PIXELS + 2)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CFG_W-1:0]  wr_data,
    output logic              sensor_clk,
    output logic              sensor_si,
    output logic              adc_strobe,
    output logic [IDX_W-1:0]  pixel_idx,
    output logic              frame_done
);

    seq_cfg_t          cfg;
    logic              cont_mode;
    logic              start_req;
    logic              cfg_ok;
    logic              run;
    logic              tick_rise;
    logic              tick_fall;
    logic [CFG_W-1:0]  act_half;
    logic [CFG_W-1:0]  act_settle;
    logic [EDGE_W-1:0] edge_cnt;
    logic              int_zero;

    assign cfg_ok = cfg_valid(cfg, MIN_HALF, MIN_SETTLE, MIN_INT);

    seq_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cfg       (cfg),
        .cont_mode (cont_mode),
        .start_req (start_req)
    );

    seq_frame_ctl #(
        .PIXELS     (PIXELS),
        .RESET_CLKS (RESET_CLKS)
    ) u_frame (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .cfg_ok     (cfg_ok),
        .start_req  (start_req),
        .cont_mode  (cont_mode),
        .tick_rise  (tick_rise),
        .tick_fall  (tick_fall),
        .run        (run),
        .si         (sensor_si),
        .done       (frame_done),
        .act_half   (act_half),
        .act_settle (act_settle),
        .edge_cnt   (edge_cnt),
        .int_zero   (int_zero)
    );

    seq_sclk_gen u_sclk (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .half      (act_half),
        .sclk      (sensor_clk),
        .tick_rise (tick_rise),
        .tick_fall (tick_fall)
    );

    seq_strobe_gen #(
        .PIXELS (PIXELS)
    ) u_strobe (
        .clk       (clk),
        .rst       (rst),
        .tick_rise (tick_rise),
        .edge_cnt  (edge_cnt),
        .settle    (act_settle),
        .strobe    (adc_strobe),
        .pix_idx   (pixel_idx)
    );

endmodule

// File: rtl/lsa_readout_seq_chk.sv
module lsa_readout_seq_chk #(
    parameter int PIXELS = 1280,
    parameter int IDX_W  = 11,
    parameter int EDGE_W = 11
)(
    input logic              clk,
    input logic              rst,
    input logic              sensor_clk,
    input logic              sensor_si,
    input logic              adc_strobe,
    input logic [IDX_W-1:0]  pixel_idx,
    input logic              frame_done,
    input logic [EDGE_W-1:0] edge_cnt,
    input logic              cfg_ok,
    input logic              int_zero
);

    p_edge_bound_r2: assert property (@(posedge clk) disable iff (rst)
        32'(edge_cnt) <= PIXELS + 1);

    p_si_rise_low_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sensor_si) |-> !sensor_clk);

    p_si_fall_with_clk_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(sensor_si) |-> $fell(sensor_clk));

    p_strobe_idx_r4: assert property (@(posedge clk) disable iff (rst)
        adc_strobe |-> (32'(pixel_idx) < PIXELS));

    p_done_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> $fell(sensor_clk));

    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    p_launch_after_int_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(sensor_si) |-> $past(int_zero));

    p_launch_cfg_ok_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(sensor_si) |-> $past(cfg_ok));

endmodule

bind lsa_readout_seq lsa_readout_seq_chk #(
    .PIXELS (PIXELS),
    .IDX_W  (IDX_W),
    .EDGE_W (EDGE_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sensor_clk (sensor_clk),
    .sensor_si  (sensor_si),
    .adc_strobe (adc_strobe),
    .pixel_idx  (pixel_idx),
    .frame_done (frame_done),
    .edge_cnt   (edge_cnt),
    .cfg_ok     (cfg_ok),
    .int_zero   (int_zero)
);

// File: tb/test_lsa_readout_seq.sv
module test_lsa_readout_seq;
    import lsa_seq_pkg::*;

    localparam int PIXELS     = 1280;
    localparam int RESET_CLKS = 18;
    localparam int IDX_W      = $clog2(PIXELS);
    localparam int NVEC       = 7;

    // {half[32:25], settle[24:17], integ[16:1], accept[0]}
    localparam logic [32:0] VEC [NVEC] = '{
        {8'd2, 8'd1, 16'd3000, 1'b1},
        {8'd3, 8'd5, 16'd3000, 1'b1},
        {8'd2, 8'd3, 16'd3000, 1'b1},
        {8'd1, 8'd1, 16'd3000, 1'b0},
        {8'd2, 8'd4, 16'd3000, 1'b0},
        {8'd2, 8'd1, 16'd2999, 1'b0},
        {8'd2, 8'd0, 16'd3000, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [CFG_W-1:0]  wr_data = '0;
    logic              sensor_clk;
    logic              sensor_si;
    logic              adc_strobe;
    logic [IDX_W-1:0]  pixel_idx;
    logic              frame_done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lsa_readout_seq #(
        .PIXELS     (PIXELS),
        .RESET_CLKS (RESET_CLKS),
        .MIN_HALF   (2),
        .MIN_SETTLE (1),
        .MIN_INT    (3000)
    ) i_lsa_readout_seq (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .sensor_clk (sensor_clk),
        .sensor_si  (sensor_si),
        .adc_strobe (adc_strobe),
        .pixel_idx  (pixel_idx),
        .frame_done (frame_done)
    );

    // ---------------- monitor ----------------
    int exp_half = 2;
    int exp_settle = 1;
    int cyc = 0;
    int m_rises, m_frame_rises, m_strobes, m_bad_strobe, m_bad_phase, m_bad_frame;
    int m_si_rises, m_si_rise_cyc, m_si_len, m_done, m_done_cyc, m_int_edge_cyc;
    int m_last_rise, m_last_fall;
    logic p_si = 1'b0;
    logic p_sclk = 1'b0;

    task automatic clr_mon();
        m_rises = 0; m_frame_rises = 0; m_strobes = 0; m_bad_strobe = 0;
        m_bad_phase = 0; m_bad_frame = 0; m_si_rises = 0; m_si_len = 0;
        m_done = 0;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (sensor_si && !p_si) begin
                m_si_rises++; m_si_rise_cyc = cyc; m_frame_rises = 0;
            end
            if (!sensor_si && p_si) m_si_len = cyc - m_si_rise_cyc;
            if (sensor_clk && !p_sclk) begin
                if (m_frame_rises == 0) begin
                    if (cyc - m_si_rise_cyc != exp_half) m_bad_phase++;
                end else if (cyc - m_last_fall != exp_half) m_bad_phase++;
                m_frame_rises++; m_rises++; m_last_rise = cyc;
                if (m_frame_rises == RESET_CLKS + 1) m_int_edge_cyc = cyc;
            end
            if (!sensor_clk && p_sclk) begin
                if (cyc - m_last_rise != exp_half) m_bad_phase++;
                m_last_fall = cyc;
            end
            if (adc_strobe) begin
                m_strobes++;
                if (cyc - m_last_rise != exp_settle || int'(pixel_idx) != m_frame_rises - 1)
                    m_bad_strobe++;
            end
            if (frame_done) begin
                m_done++; m_done_cyc = cyc;
                if (m_frame_rises != PIXELS + 1) m_bad_frame++;
            end
        end
        p_si = sensor_si;
        p_sclk = sensor_clk;
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = CFG_W'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic program_cfg(input int h, input int s, input int n);
        wr(4, h); wr(6, s); wr(5, n);
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (frame_done) begin ok = 1'b1; break; end
        end
        #1;
    endtask

    task automatic wait_si(output bit ok);
        logic prev;
        prev = sensor_si;
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (sensor_si && !prev) begin ok = 1'b1; break; end
            prev = sensor_si;
        end
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        bit ok;
        int e19;
        clr_mon();
        idle(5);
        // R1: reset state, sampled while reset is held
        check(!sensor_clk && !sensor_si && !adc_strobe && !frame_done, "R1 reset outputs",
              int'({sensor_clk, sensor_si, adc_strobe, frame_done}), 0);
        @(negedge clk); rst = 1'b0;
        idle(50);
        check(m_si_rises == 0 && m_rises == 0, "R1 quiet after reset", m_si_rises + m_rises, 0);

        // table of configurations
        for (int v = 0; v < NVEC; v++) begin
            int h, s, n;
            bit acc;
            h = int'(VEC[v][32:25]); s = int'(VEC[v][24:17]);
            n = int'(VEC[v][16:1]);  acc = VEC[v][0];
            program_cfg(h, s, n);
            exp_half = h; exp_settle = s;
            clr_mon();
            wr(0, 0);
            if (acc) begin
                wait_done(ok);
                check(ok && m_rises == PIXELS + 1, "R2 edge count", m_rises, PIXELS + 1);
                check(m_bad_phase == 0, "R2 phase width", m_bad_phase, 0);
                check(m_si_len == 2 * h, "R3 si width", m_si_len, 2 * h);
                check(m_strobes == PIXELS && m_bad_strobe == 0, "R4 strobes",
                      m_strobes - m_bad_strobe, PIXELS);
                check(m_done == 1 && m_bad_frame == 0, "R5 done", m_done, 1);
                idle(20);
            end else begin
                idle(300);
                check(m_si_rises == 0 && m_rises == 0, "R7 refused start",
                      m_si_rises + m_rises, 0);
            end
        end

        // R8: mid-frame write does not disturb the running frame
        program_cfg(2, 1, 3000);
        exp_half = 2; exp_settle = 1;
        clr_mon();
        wr(0, 0);
        idle(200);
        wr(4, 3); wr(6, 2);
        wait_done(ok);
        check(ok && m_bad_phase == 0 && m_rises == PIXELS + 1, "R8 frame kept old half",
              m_bad_phase, 0);
        check(m_bad_strobe == 0, "R8 frame kept old settle", m_bad_strobe, 0);
        idle(20);
        exp_half = 3; exp_settle = 2;
        clr_mon();
        wr(0, 0);
        wait_done(ok);
        check(ok && m_bad_phase == 0 && m_si_len == 6, "R8 next frame uses new half",
              m_si_len, 6);
        check(m_bad_strobe == 0 && m_strobes == PIXELS, "R8 next frame uses new settle",
              m_bad_strobe, 0);

        // R9: a start requested during a frame gives exactly one more frame
        idle(20);
        clr_mon();
        wr(0, 0);
        idle(500);
        wr(0, 0);
        wait_done(ok);
        wait_done(ok);
        idle(9000);
        check(m_si_rises == 2 && m_done == 2, "R9 queued single frame", m_si_rises, 2);

        // R6 / R10: continuous mode with long integration
        program_cfg(2, 1, 6000);
        exp_half = 2; exp_settle = 1;
        clr_mon();
        wr(1, 0);
        wait_done(ok);
        e19 = m_int_edge_cyc;
        wait_si(ok);
        check(ok && m_si_rise_cyc - e19 == 6001, "R6 integration sets next start",
              m_si_rise_cyc - e19, 6001);
        wr(5, 3000);
        wait_done(ok);
        e19 = m_int_edge_cyc;
        wait_si(ok);
        check(ok && m_si_rise_cyc - e19 == 6001, "R8 integration captured at launch",
              m_si_rise_cyc - e19, 6001);
        wait_done(ok);
        wait_si(ok);
        check(ok && m_si_rise_cyc - m_done_cyc == 1, "R6 short integration back to back",
              m_si_rise_cyc - m_done_cyc, 1);
        check(m_bad_phase == 0 && m_bad_strobe == 0 && m_bad_frame == 0,
              "R10 continuous frames well formed",
              m_bad_phase + m_bad_strobe + m_bad_frame, 0);
        idle(300);
        wr(2, 0);
        wait_done(ok);
        begin
            int r;
            r = m_si_rises;
            idle(7000);
            check(m_si_rises == r, "R10 stop after current frame", m_si_rises - r, 0);
        end

        finish_run();
    end

endmodule